// File: doc/BRIEF.md
# Qualified Clock Source Manager

This block supervises three clock sources for a set of clock domains: an external crystal oscillator, a PLL that runs from that oscillator, and an internal low-power oscillator. Software sends single-cycle pulses to enable a source, disable a source, or move one domain onto a source. The block keeps an enable flag for each source and derives a valid flag for it. It accepts a request only when the request is safe. Every refused request sets one sticky error flag.

The block also watches the oscillator for faults. Monitoring starts only after a start-up window, counted in ticks of the low-power oscillator, that begins when power-on reset is released. When a fault is seen, every domain that runs from the oscillator or from the PLL moves to the low-power oscillator. The analog sources, lock detection and the glitch-free mux cells sit outside the block. They appear here only as ready and fault inputs, and the block drives the per-domain select codes that control them.

Top module: `clk_src_mgr`

## Requirements
- R1: After reset, the enable flags are oscillator=1, PLL=0, low-power oscillator=1. Every domain selects code 2. The error flag, the fault flag and the monitor-active flag are all 0.
- R2: The source codes are 0 for the oscillator, 1 for the PLL, 2 for the low-power oscillator, and 3 is reserved. A switch request changes the domain's select at the next edge only if the target is enabled and its ready input is high. Otherwise the request is dropped and the domain keeps its select. A request with code 3 is always dropped.
- R3: The valid flag of a source equals its enable flag ANDed with its ready input. It falls in the same cycle in which the enable clears.
- R4: A request to disable a source is refused while any domain selects that source, counting a switch accepted in the same cycle.
- R5: A request to disable the oscillator is refused while the PLL is enabled, or is being enabled in the same cycle, even if no domain uses either source.
- R6: A refused switch or refused disable sets the error flag. The flag holds until err_clr_i is pulsed. If a refusal and a clear arrive in the same cycle, the flag stays set.
- R7: The monitor becomes active only after STARTUP_TICKS low-power ticks following reset and then stays active. A fault input seen before that has no effect.
- R8: While the monitor is active and the oscillator is enabled, a fault input sets the sticky fault flag. At the same edge, every domain on code 0 or 1 moves to code 2. After that, switches to code 0 or 1 are refused.
- R9: An enable pulse and a disable pulse for the same source in the same cycle leave the source enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| lpo_tick_i | input | 1 | One pulse per low-power oscillator period |
| src_ready_i | input | 3 | Raw ready/lock per source (bit = source code) |
| osc_fault_i | input | 1 | Oscillator fault detector output |
| en_set_i | input | 3 | Enable request per source |
| en_clr_i | input | 3 | Disable request per source |
| sel_req_i | input | 1 | Domain switch request strobe |
| sel_dom_i | input | DOM_W | Domain index for the switch |
| sel_src_i | input | 2 | Target source code |
| err_clr_i | input | 1 | Write-one-to-clear for the error flag |
| src_en_o | output | 3 | Enable flags |
| src_valid_o | output | 3 | Valid flags |
| dom_sel_o | output | 2*N_DOM | Select code per domain, domain 0 in the low bits |
| mon_active_o | output | 1 | Fault monitor armed |
| osc_fault_o | output | 1 | Sticky oscillator fault flag |
| err_o | output | 1 | Sticky refused-request flag |

## Verification
The assertions check several rules on every cycle:
- every domain points at an enabled source;
- after a fault, no domain runs from the oscillator or the PLL;
- a select changes only through a qualified request or a fallback;
- the oscillator never turns off while the PLL was on;
- the error flag is sticky;
- a fault is flagged only once the monitor is armed.

Only the bench scenarios show the rest. These cover the exact refusal of each unsafe case, including the oscillator's indirect use by an idle PLL, the priority when clear meets set, and the tick count at which the monitor arms.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int unsigned NSRC  = 3;
  localparam int unsigned SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SRC_OSC = 2'd0,
    SRC_PLL = 2'd1,
    SRC_LPO = 2'd2,
    SRC_RSV = 2'd3
  } src_e;
endpackage

// File: rtl/clk_src_startup.sv
module clk_src_startup #(
  parameter  int unsigned TICKS = 2_000_000,
  localparam int unsigned CW    = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic active_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= CW'(TICKS);
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q == '0);

  p_stays_armed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> active_o);
  p_arms_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(tick_i));
endmodule

// File: rtl/clk_src_domain.sv
module clk_src_domain
  import clk_src_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  src_e tgt_i,
  input  logic fallback_i,
  output src_e sel_d_o,
  output src_e sel_o
);
  src_e sel_q;

  always_comb begin
    sel_d_o = sel_q;
    if (fallback_i && sel_q != SRC_LPO) sel_d_o = SRC_LPO;
    else if (wr_i)                      sel_d_o = tgt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SRC_LPO;
    else         sel_q <= sel_d_o;
  end

  assign sel_o = sel_q;

  p_no_rsv_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q != SRC_RSV);
  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !fallback_i |=> $stable(sel_q));
endmodule

// File: rtl/clk_src_mgr.sv
module clk_src_mgr
  import clk_src_pkg::*;
#(
  parameter  int unsigned N_DOM         = 2,
  parameter  int unsigned STARTUP_TICKS = 2_000_000,
  localparam int unsigned DOM_W         = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lpo_tick_i,
  input  logic [NSRC-1:0]        src_ready_i,
  input  logic                   osc_fault_i,
  input  logic [NSRC-1:0]        en_set_i,
  input  logic [NSRC-1:0]        en_clr_i,
  input  logic                   sel_req_i,
  input  logic [DOM_W-1:0]       sel_dom_i,
  input  logic [SEL_W-1:0]       sel_src_i,
  input  logic                   err_clr_i,
  output logic [NSRC-1:0]        src_en_o,
  output logic [NSRC-1:0]        src_valid_o,
  output logic [N_DOM*SEL_W-1:0] dom_sel_o,
  output logic                   mon_active_o,
  output logic                   osc_fault_o,
  output logic                   err_o
);
  localparam logic [NSRC-1:0] EN_RST = 3'b101;

  logic [NSRC-1:0] en_q, en_d, clr_ok;
  logic [3:0]      en_pad, vld_pad, used_nx;
  logic            fault_q, fault_det, fault_any;
  logic            err_q, sel_ok, tgt_valid, rej;
  logic            mon_active;
  src_e            tgt;
  src_e            sel_w  [N_DOM];
  src_e            sel_nx [N_DOM];

  clk_src_startup #(.TICKS(STARTUP_TICKS)) i_startup (
    .clk_i, .rst_ni, .tick_i(lpo_tick_i), .active_o(mon_active)
  );

  assign src_valid_o = en_q & src_ready_i;
  assign en_pad      = {1'b0, en_q};
  assign vld_pad     = {1'b0, src_valid_o};
  assign tgt         = src_e'(sel_src_i);
  assign tgt_valid   = vld_pad[sel_src_i];

  assign fault_det = mon_active && osc_fault_i && en_q[SRC_OSC];
  assign fault_any = fault_q || fault_det;

  // switch qualified by enable and ready; fault locks out OSC and PLL
  assign sel_ok = sel_req_i && (int'(sel_dom_i) < N_DOM) && tgt != SRC_RSV
                  && tgt_valid && !(fault_any && tgt != SRC_LPO);

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    clk_src_domain i_dom (
      .clk_i, .rst_ni,
      .wr_i      (sel_ok && sel_dom_i == DOM_W'(d)),
      .tgt_i     (tgt),
      .fallback_i(fault_any),
      .sel_d_o   (sel_nx[d]),
      .sel_o     (sel_w[d])
    );
    assign dom_sel_o[d*SEL_W +: SEL_W] = sel_w[d];

    p_sel_enabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_pad[sel_w[d]]);
    p_fault_on_lpo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_q |-> sel_w[d] == SRC_LPO);
    p_switch_qualified_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sel_w[d]) |-> $past(fault_any)
        || ($past(sel_req_i) && $past(tgt_valid) && $past(sel_src_i) == sel_w[d]));
  end

  always_comb begin
    used_nx = '0;
    for (int d = 0; d < N_DOM; d++) used_nx[sel_nx[d]] = 1'b1;
  end

  // disable refused while used, or OSC while PLL is (or becomes) enabled
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      clr_ok[s] = en_clr_i[s] && !used_nx[s];
    end
    if (en_q[SRC_PLL] || en_set_i[SRC_PLL]) clr_ok[SRC_OSC] = 1'b0;
  end

  assign en_d = (en_q & ~clr_ok) | en_set_i;
  assign rej  = (sel_req_i && !sel_ok) || |(en_clr_i & ~clr_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= EN_RST;
      fault_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      fault_q <= fault_any;
      err_q   <= rej || (err_q && !err_clr_i);
    end
  end

  assign src_en_o     = en_q;
  assign mon_active_o = mon_active;
  assign osc_fault_o  = fault_q;
  assign err_o        = err_q;

  p_osc_kept_for_pll_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q[SRC_OSC]) |-> !$past(en_q[SRC_PLL]));
  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !err_clr_i |=> err_q);
  p_fault_needs_mon_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(mon_active));
  p_valid_follows_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_o & ~src_en_o) == '0);
endmodule

// File: tb/test_clk_src_mgr.sv
module test_clk_src_mgr;
  localparam int N_DOM = 2;
  localparam int TICKS = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic lpo_tick_i = 0, osc_fault_i = 0, sel_req_i = 0, err_clr_i = 0;
  logic [2:0] src_ready_i = 3'b111, en_set_i = 0, en_clr_i = 0;
  logic [0:0] sel_dom_i = 0;
  logic [1:0] sel_src_i = 0;
  logic [2:0] src_en_o, src_valid_o;
  logic [2*N_DOM-1:0] dom_sel_o;
  logic mon_active_o, osc_fault_o, err_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [2:0] m_en;
  logic [1:0] m_sel [N_DOM];
  logic m_err, m_fault;
  int m_cnt;

  always #5 clk_i = ~clk_i;

  clk_src_mgr #(.N_DOM(N_DOM), .STARTUP_TICKS(TICKS)) i_clk_src_mgr (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*N_DOM-1:0] exp_sel();
    logic [2*N_DOM-1:0] v;
    for (int d = 0; d < N_DOM; d++) v[d*2 +: 2] = m_sel[d];
    return v;
  endfunction

  task automatic model_reset();
    m_en = 3'b101; m_err = 0; m_fault = 0; m_cnt = TICKS;
    for (int d = 0; d < N_DOM; d++) m_sel[d] = 2'd2;
  endtask

  // one clock: expected next state from the requirements, then compare
  task automatic cyc();
    logic [3:0] enp, rdp, used;
    logic [1:0] nsel [N_DOM];
    logic [2:0] ok;
    logic mon, fany, sok, rej;
    enp = {1'b0, m_en}; rdp = {1'b0, src_ready_i};
    mon  = (m_cnt == 0);
    fany = m_fault || (mon && osc_fault_i && m_en[0]);
    sok  = sel_req_i && sel_src_i != 2'd3 && enp[sel_src_i] && rdp[sel_src_i]
           && !(fany && sel_src_i != 2'd2);
    used = 0;
    for (int d = 0; d < N_DOM; d++) begin
      if (fany && m_sel[d] != 2'd2) nsel[d] = 2'd2;
      else if (sok && sel_dom_i == d) nsel[d] = sel_src_i;
      else nsel[d] = m_sel[d];
      used[nsel[d]] = 1'b1;
    end
    for (int s = 0; s < 3; s++) ok[s] = en_clr_i[s] && !used[s];
    if (m_en[1] || en_set_i[1]) ok[0] = 1'b0;
    rej = (sel_req_i && !sok) || |(en_clr_i & ~ok);
    @(posedge clk_i); #1;
    m_en = (m_en & ~ok) | en_set_i;
    for (int d = 0; d < N_DOM; d++) m_sel[d] = nsel[d];
    m_err = rej || (m_err && !err_clr_i);
    m_fault = fany;
    if (lpo_tick_i && m_cnt != 0) m_cnt--;
    chk("R4 enables", src_en_o, m_en);
    chk("R2 selects", dom_sel_o, exp_sel());
    chk("R6 error", err_o, m_err);
    chk("R8 fault", osc_fault_o, m_fault);
    chk("R3 valid", src_valid_o, m_en & src_ready_i);
    chk("R7 monitor", mon_active_o, m_cnt == 0);
    sel_req_i = 0; en_set_i = 0; en_clr_i = 0; err_clr_i = 0; lpo_tick_i = 0;
  endtask

  task automatic sw(input int d, input int s);
    sel_req_i = 1; sel_dom_i = 1'(d); sel_src_i = 2'(s); cyc();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    model_reset();
    #23 rst_ni = 1;
    #1;
    // R1 reset state
    chk("R1 en", src_en_o, 3'b101);
    chk("R1 sel", dom_sel_o, {N_DOM{2'd2}});
    chk("R1 flags", {err_o, osc_fault_o, mon_active_o}, 3'b000);
    // R7 early fault ignored
    osc_fault_i = 1; cyc(); cyc(); osc_fault_i = 0;
    chk("R7 early fault", osc_fault_o, 1'b0);
    // R2 qualified switches
    sw(0, 0); chk("R2 dom0 to osc", dom_sel_o[1:0], 2'd0);
    sw(1, 1); chk("R2 pll disabled", dom_sel_o[3:2], 2'd2);
    chk("R6 err set", err_o, 1'b1);
    err_clr_i = 1; sw(1, 3); chk("R6 set wins", err_o, 1'b1);
    err_clr_i = 1; cyc(); chk("R6 cleared", err_o, 1'b0);
    en_set_i = 3'b010; cyc();
    src_ready_i = 3'b101; sw(1, 1); chk("R2 pll not ready", dom_sel_o[3:2], 2'd2);
    src_ready_i = 3'b111; sw(1, 1); chk("R2 pll taken", dom_sel_o[3:2], 2'd1);
    // R4 / R5 disables
    en_clr_i = 3'b001; cyc(); chk("R4 osc in use", src_en_o[0], 1'b1);
    sw(0, 2); sw(1, 2);
    en_clr_i = 3'b001; cyc(); chk("R5 osc under idle pll", src_en_o[0], 1'b1);
    chk("R6 err on refuse", err_o, 1'b1);
    en_clr_i = 3'b010; cyc(); chk("R3 pll valid drops", src_valid_o[1], 1'b0);
    en_clr_i = 3'b001; cyc(); chk("R5 osc freed", src_en_o[0], 1'b0);
    en_set_i = 3'b010; en_clr_i = 3'b001; cyc(); chk("R5 osc clear same as pll set", src_en_o, 3'b110);
    // R9 set beats clear
    en_set_i = 3'b001; en_clr_i = 3'b001; cyc(); chk("R9 set wins", src_en_o[0], 1'b1);
    // random phase, monitor not armed
    for (int i = 0; i < 3000; i++) begin
      src_ready_i = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b111;
      osc_fault_i = ($urandom_range(0, 49) == 0);
      sel_req_i = ($urandom_range(0, 2) == 0);
      sel_dom_i = 1'($urandom); sel_src_i = 2'($urandom);
      en_set_i = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b000;
      en_clr_i = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000;
      err_clr_i = ($urandom_range(0, 5) == 0);
      cyc();
    end
    chk("R7 no fault before arm", osc_fault_o, 1'b0);
    src_ready_i = 3'b111; osc_fault_i = 0;
    en_set_i = 3'b111; cyc();
    sw(0, 0); sw(1, 1);
    chk("R2 both on pll/osc", dom_sel_o, 4'b0100);
    for (int t = 0; t < TICKS; t++) begin
      if (t == TICKS - 1) chk("R7 not yet armed", mon_active_o, 1'b0);
      lpo_tick_i = 1; cyc();
    end
    chk("R7 armed", mon_active_o, 1'b1);
    osc_fault_i = 1; cyc(); osc_fault_i = 0;
    chk("R8 fault flag", osc_fault_o, 1'b1);
    chk("R8 fallback", dom_sel_o, {N_DOM{2'd2}});
    sw(0, 0); chk("R8 osc locked out", dom_sel_o[1:0], 2'd2);
    chk("R8 refused", err_o, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule